// File: doc/BRIEF.md
# Integer Add/Subtract Flag Unit

This block is the add path of a fixed-point execution pipeline. One shared 64-bit adder serves every add-like operation: plain add, subtract-from, the carrying and carry-extending forms, the add-minus-one and add-zero forms and their subtract counterparts, negate, and the add-immediate, add-immediate-shifted and immediate carrying forms. A small operand selector maps each opcode onto an effective first operand, an effective second operand and a carry-in. The adder then yields the result together with paired 64-bit and 32-bit carry and overflow flags.

Around the adder the unit keeps the flag conventions of the pipeline. The carry pair is written only by carrying forms, and the overflow pair only when overflow is enabled. Summary overflow is sticky. A signed condition nibble is produced for record forms. Decode, register read and writeback sit outside the block. The block takes one operation per cycle and registers every output, so a result appears one clock after the operation is presented.

Top module: `addsub_flag_unit`

## Requirements
- R1: Opcode values: 0 add, 1 subtract-from, 2 add-carrying, 3 subtract-from-carrying, 4 add-extended, 5 subtract-from-extended, 6 add-minus-one, 7 subtract-from-minus-one, 8 add-zero, 9 subtract-from-zero, 10 negate, 11 add-immediate, 12 add-immediate-shifted, 13 add-immediate-carrying, 14 subtract-from-immediate-carrying. Add forms compute A+B. Subtract-from forms compute NOT(A)+B+1, so A is the subtrahend. The extended forms use ca_in[0] in place of the +1.
- R2: The minus-one forms add all-ones to A (or to NOT(A)) plus ca_in[0]. The zero forms add zero to A (or to NOT(A)) plus ca_in[0]. Negate computes NOT(A)+1.
- R3: ca_out[0] is the carry out of bit 63 of the full sum. ca_out[1] is the carry out of bit 31 of the low 32 bits of the same operands and carry-in. ca_we is 1 exactly for opcodes 2 to 9, 13 and 14.
- R4: When oe is 1, ov_out[0] is the signed overflow of the 64-bit addition of the effective operands and ov_out[1] the signed overflow of their low 32 bits. ov_we equals oe.
- R5: cr_out is {negative, positive, zero, SO}. Bit 3 is set when result bit 63 is 1, bit 1 when the result is zero, and bit 2 otherwise. Bit 0 equals so_out. cr_we equals rc.
- R6: so_out = so_in OR (oe AND ov_out[0]). A set so_in shows in cr_out[0] even without new overflow, so a positive result gives cr_out 0x5.
- R7: The immediate is sign-extended from 16 bits. For add-immediate and add-immediate-shifted with ra_zero=1, A is taken as 0. The shifted form adds imm<<16, so with A=0 the result is imm<<16 whatever the a port holds.
- R8: Subtract-from-immediate-carrying computes NOT(A)+simm+1. It sets both carry bits from the sign-extended immediate as the register form does.
- R9: For opcodes 0, 1, 10, 11 and 12, ca_out equals ca_in and ca_we is 0. When oe is 0, ov_out equals ov_in, so_out equals so_in and ov_we is 0.
- R10: An operation presented with in_valid at a clock edge gives res_valid and all results after that edge. res_valid is 0 in the other cycles. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Opcode (R1 encoding) |
| a | input | 64 | First register operand |
| b | input | 64 | Second register operand |
| imm | input | 16 | Signed immediate |
| ra_zero | input | 1 | First source field names register zero |
| ca_in | input | 2 | Incoming {CA32, CA} |
| ov_in | input | 2 | Incoming {OV32, OV} |
| so_in | input | 1 | Incoming summary overflow |
| oe | input | 1 | Overflow-enabled form |
| rc | input | 1 | Record form |
| res_valid | output | 1 | Results valid |
| result | output | 64 | Sum |
| ca_out | output | 2 | {CA32, CA} |
| ca_we | output | 1 | Carry pair is written |
| ov_out | output | 2 | {OV32, OV} |
| ov_we | output | 1 | Overflow pair is written |
| so_out | output | 1 | Updated summary overflow |
| cr_out | output | 4 | Condition nibble |
| cr_we | output | 1 | Condition nibble is written |

## Verification
The bench targets operands at the 32-bit and 64-bit sign and carry boundaries, such as 0x7FFF...FFFF, 0x8000...0000, 0x12345678_7FFFFFFF and 0x12345678_FFFFFFFF. At these points a design that took CA32 from the wrong bit, or derived OV32 from the 64-bit flags, gives flag pairs that disagree with the reference. Add-minus-one with A at zero or one and carry-in clear checks that the unit adds all-ones and not a signed -1. A wrong treatment there flips CA. Sticky SO cases with a positive result expect a condition nibble of 0x5; a unit that copied only the new overflow returns 0x4. Further cases cover a nonzero register with the register-zero source field, which must give imm<<16, and non-carrying forms, where a design that wrote the carry pair would change ca_out or raise ca_we.

// File: rtl/addsub_flag_pkg.sv
package addsub_flag_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_SUBF   = 4'd1,
        OP_ADDC   = 4'd2,
        OP_SUBFC  = 4'd3,
        OP_ADDE   = 4'd4,
        OP_SUBFE  = 4'd5,
        OP_ADDME  = 4'd6,
        OP_SUBFME = 4'd7,
        OP_ADDZE  = 4'd8,
        OP_SUBFZE = 4'd9,
        OP_NEG    = 4'd10,
        OP_ADDI   = 4'd11,
        OP_ADDIS  = 4'd12,
        OP_ADDIC  = 4'd13,
        OP_SUBFIC = 4'd14
    } addsub_op_e;

endpackage

// File: rtl/afu_operand_sel.sv
module afu_operand_sel
    import addsub_flag_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    parameter int SHIFT = 16
) (
    input  addsub_op_e       op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [IMM_W-1:0] imm,
    input  logic             ra_zero,
    input  logic             ca_bit,
    output logic [XLEN-1:0]  a_eff,
    output logic [XLEN-1:0]  b_eff,
    output logic             cin,
    output logic             ca_write
);
    localparam int EXT_W = XLEN - IMM_W;
    localparam int SH_EXT_W = XLEN - IMM_W - SHIFT;

    logic [XLEN-1:0] simm;
    logic [XLEN-1:0] simm_sh;
    logic [XLEN-1:0] a_or_zero;

    always_comb begin
        simm      = {{EXT_W{imm[IMM_W-1]}}, imm};
        simm_sh   = {{SH_EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
        a_or_zero = ra_zero ? '0 : a;
        a_eff     = a;
        b_eff     = b;
        cin       = 1'b0;
        ca_write  = 1'b0;
        unique case (op)
            OP_SUBF:   begin a_eff = ~a; cin = 1'b1; end
            OP_ADDC:   begin ca_write = 1'b1; end
            OP_SUBFC:  begin a_eff = ~a; cin = 1'b1; ca_write = 1'b1; end
            OP_ADDE:   begin cin = ca_bit; ca_write = 1'b1; end
            OP_SUBFE:  begin a_eff = ~a; cin = ca_bit; ca_write = 1'b1; end
            OP_ADDME:  begin b_eff = '1; cin = ca_bit; ca_write = 1'b1; end
            OP_SUBFME: begin a_eff = ~a; b_eff = '1; cin = ca_bit; ca_write = 1'b1; end
            OP_ADDZE:  begin b_eff = '0; cin = ca_bit; ca_write = 1'b1; end
            OP_SUBFZE: begin a_eff = ~a; b_eff = '0; cin = ca_bit; ca_write = 1'b1; end
            OP_NEG:    begin a_eff = ~a; b_eff = '0; cin = 1'b1; end
            OP_ADDI:   begin a_eff = a_or_zero; b_eff = simm; end
            OP_ADDIS:  begin a_eff = a_or_zero; b_eff = simm_sh; end
            OP_ADDIC:  begin b_eff = simm; ca_write = 1'b1; end
            OP_SUBFIC: begin a_eff = ~a; b_eff = simm; cin = 1'b1; ca_write = 1'b1; end
            default:   begin end
        endcase
    end
endmodule

// File: rtl/afu_carry_adder.sv
module afu_carry_adder #(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic [XLEN-1:0] a_eff,
    input  logic [XLEN-1:0] b_eff,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic [1:0]      carry,
    output logic [1:0]      ovf
);
    logic [XLEN:0] full;
    logic [HALF:0] low;
    logic          same_hi;
    logic          same_lo;

    always_comb begin
        full    = {1'b0, a_eff} + {1'b0, b_eff} + {{XLEN{1'b0}}, cin};
        low     = {1'b0, a_eff[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
        sum     = full[XLEN-1:0];
        carry   = {low[HALF], full[XLEN]};
        same_hi = ~(a_eff[XLEN-1] ^ b_eff[XLEN-1]);
        same_lo = ~(a_eff[HALF-1] ^ b_eff[HALF-1]);
        ovf[0]  = (full[XLEN] ^ full[XLEN-1]) & same_hi;
        ovf[1]  = (low[HALF] ^ low[HALF-1]) & same_lo;
    end
endmodule

// File: rtl/afu_cond_gen.sv
module afu_cond_gen #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] sum,
    input  logic            so,
    output logic [3:0]      cond
);
    logic is_neg;
    logic is_zero;

    always_comb begin
        is_neg  = sum[XLEN-1];
        is_zero = (sum == '0);
        cond    = {is_neg, ~is_neg & ~is_zero, is_zero, so};
    end
endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
    import addsub_flag_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int HALF  = 32,
    parameter int IMM_W = 16,
    parameter int SHIFT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    input  logic [IMM_W-1:0] imm,
    input  logic             ra_zero,
    input  logic [1:0]       ca_in,
    input  logic [1:0]       ov_in,
    input  logic             so_in,
    input  logic             oe,
    input  logic             rc,
    output logic             res_valid,
    output logic [XLEN-1:0]  result,
    output logic [1:0]       ca_out,
    output logic             ca_we,
    output logic [1:0]       ov_out,
    output logic             ov_we,
    output logic             so_out,
    output logic [3:0]       cr_out,
    output logic             cr_we
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] result;
        logic [1:0]      ca;
        logic            ca_we;
        logic [1:0]      ov;
        logic            ov_we;
        logic            so;
        logic [3:0]      cr;
        logic            cr_we;
    } stage_t;

    stage_t st_d;
    stage_t st_q;

    logic [XLEN-1:0] a_eff;
    logic [XLEN-1:0] b_eff;
    logic            cin;
    logic            ca_write;
    logic [XLEN-1:0] sum;
    logic [1:0]      carry;
    logic [1:0]      ovf;
    logic            so_next;
    logic [3:0]      cond;

    afu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_sel (
        .op       (addsub_op_e'(op)),
        .a        (a),
        .b        (b),
        .imm      (imm),
        .ra_zero  (ra_zero),
        .ca_bit   (ca_in[0]),
        .a_eff    (a_eff),
        .b_eff    (b_eff),
        .cin      (cin),
        .ca_write (ca_write)
    );

    afu_carry_adder #(.XLEN(XLEN), .HALF(HALF)) u_add (
        .a_eff (a_eff),
        .b_eff (b_eff),
        .cin   (cin),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf)
    );

    assign so_next = so_in | (oe & ovf[0]);

    afu_cond_gen #(.XLEN(XLEN)) u_cond (
        .sum  (sum),
        .so   (so_next),
        .cond (cond)
    );

    always_comb begin
        st_d        = '0;
        st_d.valid  = in_valid;
        if (in_valid) begin
            st_d.result = sum;
            st_d.ca     = ca_write ? carry : ca_in;
            st_d.ca_we  = ca_write;
            st_d.ov     = oe ? ovf : ov_in;
            st_d.ov_we  = oe;
            st_d.so     = so_next;
            st_d.cr     = cond;
            st_d.cr_we  = rc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign result    = st_q.result;
    assign ca_out    = st_q.ca;
    assign ca_we     = st_q.ca_we;
    assign ov_out    = st_q.ov;
    assign ov_we     = st_q.ov_we;
    assign so_out    = st_q.so;
    assign cr_out    = st_q.cr;
    assign cr_we     = st_q.cr_we;
endmodule

// File: rtl/afu_checker.sv
module afu_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [1:0]      ca_in,
    input logic [1:0]      ov_in,
    input logic            so_in,
    input logic            res_valid,
    input logic [XLEN-1:0] result,
    input logic [1:0]      ca_out,
    input logic            ca_we,
    input logic [1:0]      ov_out,
    input logic            ov_we,
    input logic            so_out,
    input logic [3:0]      cr_out,
    input logic            cr_we
);
    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    p_so_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && so_in |=> so_out);

    p_ca_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !ca_we |-> ca_out == $past(ca_in));

    p_ov_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !ov_we |-> (ov_out == $past(ov_in)) && (so_out == $past(so_in)));

    p_cr_so_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cr_we |-> cr_out[0] == so_out);

    p_cr_class_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cr_we |-> $countones(cr_out[3:1]) == 1);

    p_cr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cr_we && result == '0 |-> cr_out[1]);
endmodule

bind addsub_flag_unit afu_checker #(.XLEN(XLEN)) u_afu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .ca_in     (ca_in),
    .ov_in     (ov_in),
    .so_in     (so_in),
    .res_valid (res_valid),
    .result    (result),
    .ca_out    (ca_out),
    .ca_we     (ca_we),
    .ov_out    (ov_out),
    .ov_we     (ov_we),
    .so_out    (so_out),
    .cr_out    (cr_out),
    .cr_we     (cr_we)
);

// File: tb/test_addsub_flag_unit.sv
`timescale 1ns/1ps
module test_addsub_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic [15:0] imm = '0;
    logic        ra_zero = 1'b0;
    logic [1:0]  ca_in = '0;
    logic [1:0]  ov_in = '0;
    logic        so_in = 1'b0;
    logic        oe = 1'b0;
    logic        rc = 1'b0;
    logic        res_valid;
    logic [63:0] result;
    logic [1:0]  ca_out;
    logic        ca_we;
    logic [1:0]  ov_out;
    logic        ov_we;
    logic        so_out;
    logic [3:0]  cr_out;
    logic        cr_we;

    always #2 clk = ~clk;

    addsub_flag_unit i_addsub_flag_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
        .imm(imm), .ra_zero(ra_zero), .ca_in(ca_in), .ov_in(ov_in), .so_in(so_in),
        .oe(oe), .rc(rc), .res_valid(res_valid), .result(result), .ca_out(ca_out),
        .ca_we(ca_we), .ov_out(ov_out), .ov_we(ov_we), .so_out(so_out),
        .cr_out(cr_out), .cr_we(cr_we)
    );

    typedef struct packed {
        logic [63:0] result;
        logic [1:0]  ca;
        logic        ca_we;
        logic [1:0]  ov;
        logic        ov_we;
        logic        so;
        logic [3:0]  cr;
        logic        cr_we;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    // Reference computed from the requirement text
    function automatic exp_t model(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                                   input logic [15:0] im, input logic rz, input logic [1:0] ci,
                                   input logic [1:0] vi, input logic si, input logic e, input logic r);
        exp_t        t;
        logic [63:0] p, q, s;
        logic        c, wr;
        logic [64:0] f;
        logic [32:0] l;
        logic        v64, v32;
        logic [63:0] se;
        se = 64'($signed(im));
        p = x; q = y; c = 1'b0; wr = 1'b0;
        case (o)
            4'd1:  begin p = ~x; c = 1'b1; end
            4'd2:  wr = 1'b1;
            4'd3:  begin p = ~x; c = 1'b1; wr = 1'b1; end
            4'd4:  begin c = ci[0]; wr = 1'b1; end
            4'd5:  begin p = ~x; c = ci[0]; wr = 1'b1; end
            4'd6:  begin q = 64'hFFFF_FFFF_FFFF_FFFF; c = ci[0]; wr = 1'b1; end
            4'd7:  begin p = ~x; q = 64'hFFFF_FFFF_FFFF_FFFF; c = ci[0]; wr = 1'b1; end
            4'd8:  begin q = 64'd0; c = ci[0]; wr = 1'b1; end
            4'd9:  begin p = ~x; q = 64'd0; c = ci[0]; wr = 1'b1; end
            4'd10: begin p = ~x; q = 64'd0; c = 1'b1; end
            4'd11: begin p = rz ? 64'd0 : x; q = se; end
            4'd12: begin p = rz ? 64'd0 : x; q = se << 16; end
            4'd13: begin q = se; wr = 1'b1; end
            4'd14: begin p = ~x; q = se; c = 1'b1; wr = 1'b1; end
            default: begin end
        endcase
        f = 65'(p) + 65'(q) + 65'(c);
        l = 33'(p[31:0]) + 33'(q[31:0]) + 33'(c);
        s = f[63:0];
        v64 = (p[63] == q[63]) && (s[63] != p[63]);
        v32 = (p[31] == q[31]) && (l[31] != p[31]);
        t.result = s;
        t.ca     = wr ? {l[32], f[64]} : ci;
        t.ca_we  = wr;
        t.ov     = e ? {v32, v64} : vi;
        t.ov_we  = e;
        t.so     = si | (e & v64);
        t.cr     = {s[63], !s[63] && s != 0, s == 0, t.so};
        t.cr_we  = r;
        return t;
    endfunction

    task automatic drive(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                         input logic [15:0] im, input logic rz, input logic [1:0] ci,
                         input logic [1:0] vi, input logic si, input logic e, input logic r);
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = y; imm = im; ra_zero = rz;
        ca_in = ci; ov_in = vi; so_in = si; oe = e; rc = r;
        exp_q.push_back(model(o, x, y, im, rz, ci, vi, si, e, r));
    endtask

    task automatic drive_lit(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y,
                             input logic [15:0] im, input logic rz, input logic [1:0] ci,
                             input logic si, input logic e, input logic r, input exp_t t);
        @(negedge clk);
        in_valid = 1'b1; op = o; a = x; b = y; imm = im; ra_zero = rz;
        ca_in = ci; ov_in = 2'b00; so_in = si; oe = e; rc = r;
        exp_q.push_back(t);
    endtask

    // Monitor: pops the oldest expectation for every valid result
    always @(negedge clk) begin
        if (rst_n && !done && res_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected res_valid", 64'd1, 64'd0);
            end else begin
                exp_t t;
                t = exp_q.pop_front();
                check("R1/R2/R7/R8 result", result, t.result);
                check("R3/R8 ca_out", 64'(ca_out), 64'(t.ca));
                check("R3/R9 ca_we", 64'(ca_we), 64'(t.ca_we));
                check("R4/R9 ov_out", 64'(ov_out), 64'(t.ov));
                check("R4 ov_we", 64'(ov_we), 64'(t.ov_we));
                check("R6 so_out", 64'(so_out), 64'(t.so));
                check("R5 cr_out", 64'(cr_out), 64'(t.cr));
                check("R5 cr_we", 64'(cr_we), 64'(t.cr_we));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    logic [63:0] vals[9] = '{64'h0, 64'h1, 64'h2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF,
                            64'h8000_0000_0000_0000, 64'h1234_5678_7FFF_FFFF,
                            64'h1234_5678_8000_0000, 64'h1234_5678_FFFF_FFFF};
    logic [15:0] imms[5] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF};

    initial begin
        exp_t t;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset res_valid", 64'(res_valid), 64'd0);
        check("R10 reset result", result, 64'd0);
        check("R10 reset flags", 64'({ca_out, ov_out, so_out, cr_out}), 64'd0);
        rst_n = 1'b1;

        // Directed R6: sticky SO with positive add-zero result gives 0x5
        t = '{result: 64'h00FF_00FF_00FF_0080, ca: 2'b00, ca_we: 1'b1, ov: 2'b00, ov_we: 1'b0,
              so: 1'b1, cr: 4'h5, cr_we: 1'b1};
        drive_lit(4'd8, 64'h00FF_00FF_00FF_0080, 64'd0, 16'd0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, t);
        // Directed R7: shifted immediate with register-zero source
        t = '{result: 64'h1_0000, ca: 2'b00, ca_we: 1'b0, ov: 2'b00, ov_we: 1'b0,
              so: 1'b0, cr: 4'h4, cr_we: 1'b1};
        drive_lit(4'd12, 64'd5, 64'd0, 16'd1, 1'b1, 2'b00, 1'b0, 1'b0, 1'b1, t);
        // Directed R2: add-minus-one on max positive with carry-in, overflow enabled
        t = '{result: 64'h7FFF_FFFF_FFFF_FFFF, ca: 2'b11, ca_we: 1'b1, ov: 2'b00, ov_we: 1'b1,
              so: 1'b0, cr: 4'h4, cr_we: 1'b1};
        drive_lit(4'd6, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, t);
        // Directed R2: add-minus-one on zero without carry-in: all-ones, no carry
        t = '{result: 64'hFFFF_FFFF_FFFF_FFFF, ca: 2'b00, ca_we: 1'b1, ov: 2'b00, ov_we: 1'b1,
              so: 1'b0, cr: 4'h8, cr_we: 1'b1};
        drive_lit(4'd6, 64'd0, 64'd0, 16'd0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, t);
        // Directed R8: subtract-from-immediate 0 - 0 carries both
        t = '{result: 64'd0, ca: 2'b11, ca_we: 1'b1, ov: 2'b00, ov_we: 1'b0,
              so: 1'b0, cr: 4'h2, cr_we: 1'b1};
        drive_lit(4'd14, 64'd0, 64'd0, 16'd0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, t);
        // Directed R1: subtract-from, A is subtrahend: 5 - 0x10
        t = '{result: 64'hFFFF_FFFF_FFFF_FFF5, ca: 2'b10, ca_we: 1'b0, ov: 2'b00, ov_we: 1'b0,
              so: 1'b0, cr: 4'h8, cr_we: 1'b1};
        drive_lit(4'd1, 64'h10, 64'h5, 16'd0, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, t);
        // Directed R4: max positive + 1 overflows 64-bit
        t = '{result: 64'h8000_0000_0000_0000, ca: 2'b10, ca_we: 1'b1, ov: 2'b01, ov_we: 1'b1,
              so: 1'b1, cr: 4'h9, cr_we: 1'b1};
        drive_lit(4'd2, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'd0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, t);

        // Sweep: every opcode, boundary operands, flag combinations (R1-R9 reference)
        for (int o = 0; o < 15; o++) begin
            for (int i = 0; i < 9; i++) begin
                for (int j = 0; j < 9; j += 2) begin
                    for (int c = 0; c < 4; c++) begin
                        drive(4'(o), vals[i], vals[j], imms[(i + j + c) % 5], 1'((i + c) % 2),
                              2'(c), 2'(3 - c), 1'((i + j) % 3 == 0), 1'(c >> 1), 1'(c & 1));
                    end
                end
            end
        end
        // R10 idle cycles produce no results
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 queue drained", 64'(exp_q.size()), 64'd0);
        check("R10 idle res_valid", 64'(res_valid), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule